// File: doc/BRIEF.md
# Triple Watchdog Timer Peripheral

This peripheral holds three independent 16-bit watchdog downcounters behind one simple register bus. The bus has an address, a byte/halfword size select, read and write strobes and 16-bit data. A shared prescaler produces a tick every `TICK_DIV` clocks, which is one tenth of a second in the system. Each running counter decrements once per tick. Software starts a timer by writing its limit register. It keeps the timer alive by reading the timer's count register, which reloads the counter from the limit.

Each timer drives a different expiry action:
- Timer 0 raises a level interrupt.
- Timer 1 pulses a CPU-only reset.
- Timer 2 pulses a system-wide reset.

A shared mask byte can gate the action of each timer. A masked timer keeps counting and still reports expiry in its status. Halfword registers travel on the bus low byte first, so both bytes are exchanged relative to bus order.

Top module: `tri_wdog`

## Requirements
- R1: After reset, every timer's count and limit hold 1, every status reads 0, the mask reads 0, and all three outputs are low.
- R2: A halfword write to a timer's limit register (offset 4 of its window) stores the value, loads the counter with it, sets running and clears expired.
- R3: On every tick (one clock in every `TICK_DIV`), a running timer's counter decrements. A tick that finds the count at 1 or 0 sets the count to 0, clears running and sets expired. The timer stays that way until its limit is written again.
- R4: A read of the count register (offset 0, either size) while the timer is running reloads the counter from the limit, and this reload wins over a tick in the same cycle. The read has no effect when the timer is not running. Reading the limit or status registers has no side effect.
- R5: Halfword registers are byte-exchanged. Read data is {reg[7:0], reg[15:8]}, and a write stores {wdata[7:0], wdata[15:8]}. A byte-size read of a halfword register returns the same exchanged 16-bit value.
- R6: The status byte at offset 8 of a timer window has bit 0 = running and bit 1 = expired. All other bits read 0.
- R7: The mask byte at address 0x30 is written with byte-size writes. Bit 0, bit 1 and bit 2 gate timers 0, 1 and 2, and a 1 disables the action. The mask reads back, and a masked timer still counts down and sets expired.
- R8: `irq_o` is high exactly while timer 0 is expired and mask bit 0 is clear.
- R9: When timer 1 or timer 2 becomes expired with its mask bit clear, `cpu_rst_o` or `sys_rst_o` respectively goes high on that same edge for `RST_LEN` cycles. If the mask bit is set at that transition, no pulse is produced, even if the mask is cleared later.
- R10: The byte at address 0x34 reads the expired flags of timers 0, 1 and 2 in bits 0, 1 and 2.
- R11: Writes of the wrong size, writes to count, status or 0x34, and writes to unmapped addresses change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data in bus byte order |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Timer 0 expiry interrupt, level |
| cpu_rst_o | output | 1 | Timer 1 expiry CPU reset pulse |
| sys_rst_o | output | 1 | Timer 2 expiry system reset pulse |

## Verification
The first pattern starts a timer and reads its count at intervals shorter than the timeout. This shows that the count read reloads the counter, as opposed to merely observing it. The second pattern lets the same timer run out, then reads the count again. This shows that expiry is sticky and that a read of an idle timer does not revive it.

The third pattern sets the mask and runs timers 1 and 2 out under it, then clears it. This separates gating of the action from gating of the count. It also confirms that a reset pulse fires only on the unmasked transition, while the interrupt follows the mask as a level.

Finally, wrong-size writes, byte reads of halfword registers and a limit of zero probe the decode, the lane exchange and the immediate-expiry corner.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int NUM_TMR   = 3;
    localparam int HW        = 16;
    localparam int AW        = 6;
    localparam int WIN_BYTES = 16;
    localparam int OFF_CNT   = 0;
    localparam int OFF_LIM   = 4;
    localparam int OFF_STS   = 8;
    localparam int ADR_MASK  = 'h30;
    localparam int ADR_SUM   = 'h34;

    function automatic logic [HW-1:0] lane_swap(input logic [HW-1:0] v);
        return {v[7:0], v[15:8]};
    endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    assign tick_o = (pre_q.cnt == PW'(DIV - 1));

    always_comb begin
        pre_d = pre_q;
        if (tick_o) pre_d.cnt = '0;
        else        pre_d.cnt = pre_q.cnt + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          kick_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] lim_o,
    output logic          run_o,
    output logic          exp_o,
    output logic          fire_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          run;
        logic          exp;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic fire_d;

    always_comb begin
        tm_d   = tm_q;
        fire_d = 1'b0;
        if (load_i) begin
            tm_d.cnt = load_val_i;
            tm_d.lim = load_val_i;
            tm_d.run = 1'b1;
            tm_d.exp = 1'b0;
        end else if (kick_i && tm_q.run) begin
            tm_d.cnt = tm_q.lim;
        end else if (tick_i && tm_q.run) begin
            if (tm_q.cnt <= CW'(1)) begin
                tm_d.cnt = '0;
                tm_d.run = 1'b0;
                tm_d.exp = 1'b1;
                fire_d   = 1'b1;
            end else begin
                tm_d.cnt = tm_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q.cnt <= CW'(1);
            tm_q.lim <= CW'(1);
            tm_q.run <= 1'b0;
            tm_q.exp <= 1'b0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign cnt_o  = tm_q.cnt;
    assign lim_o  = tm_q.lim;
    assign run_o  = tm_q.run;
    assign exp_o  = tm_q.exp;
    assign fire_o = fire_d;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pulse_o
);
    localparam int LW = $clog2(LEN + 1);

    typedef struct packed {
        logic [LW-1:0] left;
    } pls_t;

    pls_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (start_i)                pl_d.left = LW'(LEN);
        else if (pl_q.left != '0)   pl_d.left = pl_q.left - LW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    assign pulse_o = (pl_q.left != '0);
endmodule

// File: rtl/tri_wdog.sv
module tri_wdog
    import wdog_pkg::*;
#(
    parameter int TICK_DIV = 5_000_000,
    parameter int RST_LEN  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    bus_addr,
    input  logic          bus_half,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          irq_o,
    output logic          cpu_rst_o,
    output logic          sys_rst_o
);
    typedef struct packed {
        logic [NUM_TMR-1:0] mask;
    } top_t;

    top_t top_d, top_q;

    logic                        tick_w;
    logic [NUM_TMR-1:0]          kick_w, load_w, run_w, exp_w, fire_w;
    logic [NUM_TMR-1:0][HW-1:0]  cnt_w, lim_w;
    logic [NUM_TMR-1:1]          pulse_w;
    logic [HW-1:0]               wval_w;
    logic [NUM_TMR-1:0]          mask_q;

    assign wval_w = lane_swap(bus_wdata);
    assign mask_q = top_q.mask;

    wdog_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        assign kick_w[g] = bus_rd && (bus_addr == AW'(g * WIN_BYTES + OFF_CNT));
        assign load_w[g] = bus_wr && bus_half && (bus_addr == AW'(g * WIN_BYTES + OFF_LIM));

        wdog_timer #(.CW(HW)) u_tmr (
            .clk(clk), .rst_n(rst_n), .tick_i(tick_w),
            .kick_i(kick_w[g]), .load_i(load_w[g]), .load_val_i(wval_w),
            .cnt_o(cnt_w[g]), .lim_o(lim_w[g]), .run_o(run_w[g]),
            .exp_o(exp_w[g]), .fire_o(fire_w[g])
        );
    end

    for (genvar g = 1; g < NUM_TMR; g++) begin : g_pls
        wdog_pulse #(.LEN(RST_LEN)) u_pls (
            .clk(clk), .rst_n(rst_n),
            .start_i(fire_w[g] & ~top_q.mask[g]),
            .pulse_o(pulse_w[g])
        );
    end

    logic unused_fire0;
    assign unused_fire0 = fire_w[0];

    always_comb begin
        top_d = top_q;
        if (bus_wr && !bus_half && (bus_addr == AW'(ADR_MASK)))
            top_d.mask = bus_wdata[NUM_TMR-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr[5:4] == 2'(i)) begin
                case (bus_addr[3:0])
                    4'(OFF_CNT): bus_rdata = lane_swap(cnt_w[i]);
                    4'(OFF_LIM): bus_rdata = lane_swap(lim_w[i]);
                    4'(OFF_STS): bus_rdata = {14'b0, exp_w[i], run_w[i]};
                    default:     bus_rdata = '0;
                endcase
            end
        end
        if (bus_addr == AW'(ADR_MASK)) bus_rdata = {{(HW-NUM_TMR){1'b0}}, top_q.mask};
        if (bus_addr == AW'(ADR_SUM))  bus_rdata = {{(HW-NUM_TMR){1'b0}}, exp_w};
    end

    assign irq_o     = exp_w[0] & ~top_q.mask[0];
    assign cpu_rst_o = pulse_w[1];
    assign sys_rst_o = pulse_w[2];
endmodule

// File: rtl/tri_wdog_chk.sv
module tri_wdog_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  kick,
    input logic [2:0]  load,
    input logic [2:0]  run,
    input logic [2:0]  expd,
    input logic [2:0]  mask,
    input logic [15:0] cnt0,
    input logic [15:0] lim0,
    input logic        irq,
    input logic        cpu_rst,
    input logic        sys_rst
);
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load[0] |=> (run[0] && !expd[0] && cnt0 == lim0));

    a_r3_expired_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expd[0] && !load[0]) |=> (expd[0] && cnt0 == 16'd0));

    a_r3_never_climbs: assert property (@(posedge clk) disable iff (!rst_n)
        (run[0] && !load[0] && !kick[0]) |=> (cnt0 <= $past(cnt0)));

    a_r4_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (kick[0] && run[0] && !load[0]) |=> (cnt0 == $past(lim0)));

    a_r6_state_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run[0], expd[0]}) && $onehot0({run[1], expd[1]}) && $onehot0({run[2], expd[2]}));

    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(expd[0]) || $fell(mask[0])));

    a_r9_cpu_rst_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst) |-> ($rose(expd[1]) && !$past(mask[1])));

    a_r9_sys_rst_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> ($rose(expd[2]) && !$past(mask[2])));
endmodule

bind tri_wdog tri_wdog_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .kick(kick_w), .load(load_w), .run(run_w), .expd(exp_w), .mask(mask_q),
    .cnt0(cnt_w[0]), .lim0(lim_w[0]),
    .irq(irq_o), .cpu_rst(cpu_rst_o), .sys_rst(sys_rst_o)
);

// File: tb/tri_wdog_tb.sv
module tri_wdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 4;
    localparam int PLEN = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_half = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, cpu_rst_o, sys_rst_o;

    int nvec = 0;
    int nmis = 0;
    int cyc  = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_wdog #(.TICK_DIV(DIV), .RST_LEN(PLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_half(bus_half),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
    );

    // behavioural reference
    int m_cnt[3], m_lim[3], m_pc[3];
    bit m_run[3], m_exp[3];
    bit [2:0] m_mask;
    int m_pre;

    function automatic logic [15:0] sw(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 1; m_lim[i] = 1; m_run[i] = 0; m_exp[i] = 0; m_pc[i] = 0;
            end
            m_mask = 0; m_pre = 0;
        end else begin
            bit tick;
            bit fire[3];
            tick = (m_pre == DIV - 1);
            m_pre = tick ? 0 : m_pre + 1;
            for (int i = 0; i < 3; i++) begin
                fire[i] = 0;
                if (bus_wr && bus_half && bus_addr == 6'(i*16 + 4)) begin
                    m_lim[i] = int'(sw(bus_wdata)); m_cnt[i] = m_lim[i];
                    m_run[i] = 1; m_exp[i] = 0;
                end else if (bus_rd && bus_addr == 6'(i*16) && m_run[i]) begin
                    m_cnt[i] = m_lim[i];
                end else if (tick && m_run[i]) begin
                    if (m_cnt[i] <= 1) begin
                        m_cnt[i] = 0; m_run[i] = 0; m_exp[i] = 1; fire[i] = 1;
                    end else m_cnt[i] = m_cnt[i] - 1;
                end
            end
            for (int i = 1; i < 3; i++) begin
                if (fire[i] && !m_mask[i]) m_pc[i] = PLEN;
                else if (m_pc[i] > 0)      m_pc[i] = m_pc[i] - 1;
            end
            if (bus_wr && !bus_half && bus_addr == 6'h30) m_mask = bus_wdata[2:0];
        end
    end

    function automatic logic [15:0] m_rd(input logic [5:0] a);
        int i;
        if (a < 6'd48) begin
            i = int'(a[5:4]);
            case (a[3:0])
                4'h0: return sw(16'(m_cnt[i]));
                4'h4: return sw(16'(m_lim[i]));
                4'h8: return {14'b0, m_exp[i], m_run[i]};
                default: return 16'h0;
            endcase
        end
        if (a == 6'h30) return {13'b0, m_mask};
        if (a == 6'h34) return {13'b0, m_exp[2], m_exp[1], m_exp[0]};
        return 16'h0;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nvec++;
        if (got !== exp) begin
            nmis++;
            $display("FAIL %s: got 0x%04h expected 0x%04h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // outputs compared on every clock, away from the edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R8 irq_o", {15'b0, irq_o}, {15'b0, m_exp[0] && !m_mask[0]});
            chk("R9 cpu_rst_o", {15'b0, cpu_rst_o}, {15'b0, m_pc[1] > 0});
            chk("R9 sys_rst_o", {15'b0, sys_rst_o}, {15'b0, m_pc[2] > 0});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input bit half);
        @(negedge clk);
        bus_addr = a; bus_half = half; bus_rd = 1;
        #1 chk(tag, bus_rdata, m_rd(a));
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wr(input logic [5:0] a, input bit half, input logic [15:0] regval);
        @(negedge clk);
        bus_addr = a; bus_half = half; bus_wr = 1;
        bus_wdata = half ? sw(regval) : regval;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nmis++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset state, R5 lane exchange of the value 1
        for (int i = 0; i < 3; i++) begin
            rd("R1 count after reset", 6'(i*16), 1);
            rd("R1 limit after reset", 6'(i*16 + 4), 1);
            rd("R1 status after reset", 6'(i*16 + 8), 0);
        end
        chk("R5 reset count swapped", m_rd(6'h00), 16'h0100);
        rd("R1 mask after reset", 6'h30, 0);
        rd("R10 summary after reset", 6'h34, 0);
        rd("R11 unmapped read", 6'h3c, 1);

        // R2 start timer 0, R5 swapped readback
        wr(6'h04, 1, 16'h0006);
        rd("R5 limit readback", 6'h04, 1);
        chk("R5 limit lanes", m_rd(6'h04), 16'h0600);
        rd("R6 running status", 6'h08, 0);
        // R4 keep-alive reads
        for (int k = 0; k < 5; k++) begin
            idle(12);
            rd("R4 kick read", 6'h00, 1);
            rd("R6 still running", 6'h08, 0);
        end
        rd("R4 limit read no side effect", 6'h04, 1);
        // R3 run out
        idle(40);
        rd("R6 expired status", 6'h08, 0);
        rd("R3 count held at zero", 6'h00, 1);
        rd("R4 no revive when expired", 6'h08, 0);
        rd("R10 summary timer0", 6'h34, 0);
        idle(5);
        wr(6'h04, 1, 16'h0010);
        rd("R2 restart clears expired", 6'h08, 0);
        rd("R5 byte read of count", 6'h00, 0);

        // R11 ignored writes
        wr(6'h04, 0, 16'h00ff);
        rd("R11 byte write to limit ignored", 6'h04, 1);
        wr(6'h30, 1, 16'h0007);
        rd("R11 halfword write to mask ignored", 6'h30, 0);
        wr(6'h00, 1, 16'h1234);
        wr(6'h08, 0, 16'h0003);
        wr(6'h34, 0, 16'h0007);
        rd("R11 count write ignored", 6'h00, 1);
        rd("R11 status write ignored", 6'h08, 0);

        // R7 masked expiry keeps counting, R9 no pulse
        wr(6'h30, 0, 16'h0007);
        rd("R7 mask readback", 6'h30, 0);
        wr(6'h14, 1, 16'h0002);
        wr(6'h24, 1, 16'h0003);
        idle(90);
        rd("R7 masked timer0 expired", 6'h08, 0);
        rd("R7 masked timer1 expired", 6'h18, 0);
        rd("R7 masked timer2 expired", 6'h28, 0);
        rd("R10 summary all expired", 6'h34, 0);
        wr(6'h30, 0, 16'h0000);
        idle(6);
        rd("R8 irq follows unmask", 6'h30, 0);

        // R9 unmasked pulses, R3 zero limit
        wr(6'h14, 1, 16'h0002);
        idle(20);
        rd("R9 timer1 expired", 6'h18, 0);
        wr(6'h24, 1, 16'h0000);
        idle(12);
        rd("R3 zero limit expires", 6'h28, 0);
        wr(6'h04, 1, 16'h0003);
        rd("R4 byte read kick", 6'h00, 0);
        idle(30);
        rd("R10 final summary", 6'h34, 0);
        finish_run();
    end
endmodule